// File: doc/BRIEF.md
# Bit I/O Port with Pattern Test

This block serves eight general-purpose pins on behalf of a processor. Each pin is set as an input or an output through a direction command. A masked command sets, clears or toggles the output-register bits, and it changes only the bits that are configured as outputs. Input pins pass through a two-flop synchronizer. A test command compares any group of synchronized input bits against a pattern and returns two registered condition flags that a sequencer can branch on.

The upper four pins are shared with a four-bit interrupt vector-ID output. Out of reset the vector drives those pins, with its bit order reversed. Setting an enable bit in the control word hands the four pins to the bit I/O logic instead.

Top module: `bitio_port`

## Requirements
- R1: After reset the direction register is all inputs (0), the output register is 0, both flags are 0 and the pin-share enable is 0.
- R2: `cmd_op` values are 0 no-op, 1 direction load, 2 set, 3 clear, 4 toggle and 5 test, acting only while `cmd_valid` is 1. A direction load copies `cmd_mask` into the direction register (1 = output) in one cycle. `pin_oe[3:0]` follows direction bits 3:0, and `pin_oe[7:4]` follows direction bits 7:4 while the share enable is 1.
- R3: Set ORs `cmd_mask` into the output register, clear removes the masked bits and toggle inverts them. Each takes effect one cycle after the command and touches only bits whose direction is output. `pin_out[3:0]` shows output register bits 3:0.
- R4: An output-register bit whose direction is input keeps its value through any set, clear or toggle.
- R5: `rd_data` gives the output register bit for output pins. For available input pins it gives `pin_in` as it was two clock edges earlier.
- R6: One cycle after a test, `flag_all_eq` is 1 when every tested bit of the synchronized input equals the matching `cmd_pat` bit. Tested bits are those set in `cmd_mask` that are inputs and available.
- R7: One cycle after a test, `flag_none_eq` is 1 when no tested bit equals its `cmd_pat` bit.
- R8: A test with no tested bits sets both flags to 1.
- R9: The flags keep their value until the next test command.
- R10: While the share enable is 0, `pin_out[7:4]` = {vec_id[0], vec_id[1], vec_id[2], vec_id[3]} (pin 7 carries vector bit 0) and `pin_oe[7:4]` = 4'hF.
- R11: A write with `ctl_we` = 1 loads the share enable from `ctl_wdata[8]`, one cycle later. While it is 1, `pin_out[7:4]` shows output register bits 7:4.
- R12: While the share enable is 0, pins 7:4 are not available. They read as 0 in `rd_data` for input-configured pins and are left out of pattern tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_mask | input | 8 | Bit mask or direction value |
| cmd_pat | input | 8 | Pattern for test commands |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word; bit 8 is the pin-share enable |
| vec_id | input | 4 | Interrupt vector-ID to place on the shared pins |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| rd_data | output | 8 | Readback of the pin state |
| flag_all_eq | output | 1 | All tested bits match the pattern |
| flag_none_eq | output | 1 | No tested bit matches the pattern |

## Verification
The assertions assume that `cmd_op` carries only the six defined codes and that `pin_in` may change on any cycle, because the synchronizer is there to absorb that. The stimulus drives every input a fixed delay after the rising edge, so the inputs are stable at each edge. It issues only defined codes and changes `pin_in` between tests, which checks both the latency through the synchronizer and the flags holding their value.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
    localparam int BIO_W = 8;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_DIR  = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_TGL  = 3'd4,
        OP_TEST = 3'd5
    } bitio_op_e;

    typedef struct packed {
        logic [BIO_W-1:0] dir;
        logic [BIO_W-1:0] outr;
        logic             share_en;
        logic             all_eq;
        logic             none_eq;
    } bitio_state_t;
endpackage

// File: rtl/bitio_sync.sv
module bitio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;
    logic [1:0] age_q;

    always_comb begin
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            age_q <= '0;
        end else begin
            st_q <= st_d;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    assign sync_out = st_q.stab;

    // R5: the output is the input from two edges earlier
    p_two_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/bitio_core.sv
module bitio_core
    import bitio_pkg::*;
#(
    parameter int W      = BIO_W,
    parameter int SHR_W  = 4,
    parameter int CTL_W  = 16,
    parameter int EN_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_mask,
    input  logic [W-1:0]     cmd_pat,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [W-1:0]     in_sync,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     out_q,
    output logic             share_en_q,
    output logic [W-1:0]     avail,
    output logic             flag_all_eq,
    output logic             flag_none_eq
);
    localparam int LOW_W = W - SHR_W;

    bitio_state_t st_d, st_q;
    logic [W-1:0] tested, hits, wmask;

    always_comb begin
        avail  = {{SHR_W{st_q.share_en}}, {LOW_W{1'b1}}};
        tested = cmd_mask & ~st_q.dir & avail;
        hits   = ~(in_sync ^ cmd_pat) & tested;
        wmask  = cmd_mask & st_q.dir;
        st_d   = st_q;
        if (ctl_we) st_d.share_en = ctl_wdata[EN_BIT];
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_DIR:  st_d.dir  = cmd_mask;
                OP_SET:  st_d.outr = st_q.outr | wmask;
                OP_CLR:  st_d.outr = st_q.outr & ~wmask;
                OP_TGL:  st_d.outr = st_q.outr ^ wmask;
                OP_TEST: begin
                    st_d.all_eq  = (hits == tested);
                    st_d.none_eq = (hits == '0);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q        = st_q.dir;
    assign out_q        = st_q.outr;
    assign share_en_q   = st_q.share_en;
    assign flag_all_eq  = st_q.all_eq;
    assign flag_none_eq = st_q.none_eq;

    // R4: bits configured as inputs never change in the output register
    p_inputs_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op != OP_DIR)) |=>
        ((out_q & ~dir_q) == ($past(out_q) & ~dir_q)));

    // R9: flags stay put without a test command
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == OP_TEST) |=>
        ($stable(flag_all_eq) && $stable(flag_none_eq)));

    // R8: with at least one tested bit the two flags cannot both be set
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_TEST && tested != '0) |=>
        !(flag_all_eq && flag_none_eq));

    // R2: only defined codes arrive
    p_op_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op <= OP_TEST));
endmodule

// File: rtl/bitio_pinmux.sv
module bitio_pinmux #(
    parameter int W     = 8,
    parameter int SHR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             share_en,
    input  logic [SHR_W-1:0] vec_id,
    input  logic [W-1:0]     out_q,
    input  logic [W-1:0]     dir_q,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    localparam int LOW_W = W - SHR_W;

    logic [SHR_W-1:0] vec_rev;

    for (genvar i = 0; i < SHR_W; i++) begin : g_rev
        assign vec_rev[SHR_W-1-i] = vec_id[i];
    end

    always_comb begin
        pin_out[LOW_W-1:0] = out_q[LOW_W-1:0];
        pin_oe[LOW_W-1:0]  = dir_q[LOW_W-1:0];
        if (share_en) begin
            pin_out[W-1:LOW_W] = out_q[W-1:LOW_W];
            pin_oe[W-1:LOW_W]  = dir_q[W-1:LOW_W];
        end else begin
            pin_out[W-1:LOW_W] = vec_rev;
            pin_oe[W-1:LOW_W]  = '1;
        end
    end

    // R10: top pin carries the lowest vector bit while the vector owns the pins
    p_vec_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !share_en |-> (pin_out[W-1] == vec_id[0] && pin_out[LOW_W] == vec_id[SHR_W-1]));
endmodule

// File: rtl/bitio_port.sv
module bitio_port
    import bitio_pkg::*;
#(
    parameter int W      = BIO_W,
    parameter int SHR_W  = 4,
    parameter int CTL_W  = 16,
    parameter int EN_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_mask,
    input  logic [W-1:0]     cmd_pat,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [SHR_W-1:0] vec_id,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     rd_data,
    output logic             flag_all_eq,
    output logic             flag_none_eq
);
    logic [W-1:0] in_sync, dir_q, out_q, avail;
    logic         share_en_q;

    bitio_sync #(.W(W)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync)
    );

    bitio_core #(.W(W), .SHR_W(SHR_W), .CTL_W(CTL_W), .EN_BIT(EN_BIT)) core_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_pat(cmd_pat),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .in_sync(in_sync),
        .dir_q(dir_q), .out_q(out_q), .share_en_q(share_en_q), .avail(avail),
        .flag_all_eq(flag_all_eq), .flag_none_eq(flag_none_eq)
    );

    bitio_pinmux #(.W(W), .SHR_W(SHR_W)) mux_i (
        .clk(clk), .rst_n(rst_n), .share_en(share_en_q), .vec_id(vec_id),
        .out_q(out_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign rd_data = (dir_q & out_q) | (~dir_q & in_sync & avail);

    // R12: unavailable input pins read as zero
    p_hidden_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !share_en_q |-> ((rd_data & ~dir_q & {{SHR_W{1'b1}}, {(W-SHR_W){1'b0}}}) == '0));
endmodule

// File: tb/bitio_port_tb.sv
module bitio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_mask = 8'h00, cmd_pat = 8'h00;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = 16'h0000;
    logic [3:0]  vec_id = 4'b0001;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  pin_out, pin_oe, rd_data;
    logic        flag_all_eq, flag_none_eq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bitio_port dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .cmd_pat(cmd_pat), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .vec_id(vec_id), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .rd_data(rd_data), .flag_all_eq(flag_all_eq), .flag_none_eq(flag_none_eq)
    );

    // behavioural reference model
    logic [7:0] m_dir, m_out, m_s1, m_s2;
    logic       m_en, m_all, m_none;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0;
            m_en <= 0; m_all <= 0; m_none <= 0;
        end else begin
            logic [7:0] av, tst;
            int hitcnt, tcnt;
            av = m_en ? 8'hFF : 8'h0F;
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (ctl_we) m_en <= ctl_wdata[8];
            if (cmd_valid) begin
                case (cmd_op)
                    3'd1: m_dir <= cmd_mask;
                    3'd2: m_out <= m_out | (cmd_mask & m_dir);
                    3'd3: m_out <= m_out & ~(cmd_mask & m_dir);
                    3'd4: m_out <= m_out ^ (cmd_mask & m_dir);
                    3'd5: begin
                        tst = cmd_mask & ~m_dir & av;
                        hitcnt = 0; tcnt = 0;
                        for (int b = 0; b < 8; b++)
                            if (tst[b]) begin
                                tcnt++;
                                if (m_s2[b] == cmd_pat[b]) hitcnt++;
                            end
                        m_all  <= (hitcnt == tcnt);
                        m_none <= (hitcnt == 0);
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e_out, e_oe, e_rd, av;
            av = m_en ? 8'hFF : 8'h0F;
            e_out[3:0] = m_out[3:0];
            e_oe[3:0]  = m_dir[3:0];
            e_out[7:4] = m_en ? m_out[7:4] : {vec_id[0], vec_id[1], vec_id[2], vec_id[3]};
            e_oe[7:4]  = m_en ? m_dir[7:4] : 4'hF;
            e_rd = (m_dir & m_out) | (~m_dir & m_s2 & av);
            chk("R3 pin_out low", {4'h0, pin_out[3:0]}, {4'h0, e_out[3:0]});
            chk(m_en ? "R11 pin_out high" : "R10 pin_out high", {4'h0, pin_out[7:4]}, {4'h0, e_out[7:4]});
            chk("R2 pin_oe", pin_oe, e_oe);
            chk("R5 rd_data", rd_data, e_rd);
            chk("R6 flag_all_eq", {7'h0, flag_all_eq}, {7'h0, m_all});
            chk("R7 flag_none_eq", {7'h0, flag_none_eq}, {7'h0, m_none});
        end
    end

    task automatic cmd(logic [2:0] op, logic [7:0] mask, logic [7:0] pat);
        @(posedge clk); #1;
        ctl_we = 0; cmd_valid = 1; cmd_op = op; cmd_mask = mask; cmd_pat = pat;
    endtask

    task automatic ctl(logic [15:0] w);
        @(posedge clk); #1;
        cmd_valid = 0; ctl_we = 1; ctl_wdata = w;
    endtask

    task automatic idle(int n);
        @(posedge clk); #1;
        cmd_valid = 0; ctl_we = 0;
        repeat (n - 1) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        fails++; checks++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic sa, sn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle(1);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'hF0);
        chk("R1 out low", {4'h0, pin_out[3:0]}, 8'h00);
        chk("R1 flags", {6'h0, flag_all_eq, flag_none_eq}, 8'h00);
        // R10 vector bit 0 appears on pin 7
        chk("R10 reversal", {4'h0, pin_out[7:4]}, 8'h08);
        vec_id = 4'b0110; idle(1);
        vec_id = 4'b0011; idle(1);
        chk("R10 reversal 2", {4'h0, pin_out[7:4]}, 8'h0C);

        // R12 upper pins hidden from readback while vector owns them
        pin_in = 8'hFF; idle(3);
        chk("R12 hidden read", rd_data, 8'h0F);
        // R8 and R12: test with only unavailable bits -> empty -> both flags
        cmd(3'd5, 8'hF0, 8'h00); idle(1);
        chk("R8 empty test", {6'h0, flag_all_eq, flag_none_eq}, 8'h03);

        // R6 / R7 on low pins
        cmd(3'd5, 8'h0F, 8'h0F); idle(1);
        chk("R6 all match", {6'h0, flag_all_eq, flag_none_eq}, 8'h02);
        cmd(3'd5, 8'h0F, 8'h00); idle(1);
        chk("R7 none match", {6'h0, flag_all_eq, flag_none_eq}, 8'h01);
        pin_in = 8'h05; idle(3);
        cmd(3'd5, 8'h03, 8'h01); idle(1);
        cmd(3'd5, 8'h06, 8'h00); idle(1);
        chk("R6 R7 partial", {6'h0, flag_all_eq, flag_none_eq}, 8'h00);

        // R9 flags hold while inputs move
        sa = flag_all_eq; sn = flag_none_eq;
        pin_in = 8'hA3; idle(4);
        chk("R9 hold", {6'h0, flag_all_eq, flag_none_eq}, {6'h0, sa, sn});

        // R11 share enable through control bit 8
        ctl(16'h0100); idle(1);
        chk("R11 oe high follows dir", pin_oe, 8'h00);
        // R2 direction and R3 set/clear/toggle, R4 input bits untouched
        cmd(3'd1, 8'h0F, 8'h00);
        cmd(3'd2, 8'hFF, 8'h00); idle(1);
        cmd(3'd1, 8'hFF, 8'h00); idle(1);
        chk("R4 input bits untouched", pin_out, 8'h0F);
        cmd(3'd3, 8'h0A, 8'h00);
        cmd(3'd4, 8'hF0, 8'h00); idle(1);
        chk("R3 clear then toggle", pin_out, 8'hF5);
        cmd(3'd0, 8'hFF, 8'h00);
        cmd(3'd1, 8'h3C, 8'h00); idle(1);
        chk("R2 dir load", pin_oe, 8'h3C);
        pin_in = 8'h81; idle(3);
        cmd(3'd5, 8'hC3, 8'h81); idle(1);
        chk("R6 with upper pins", {6'h0, flag_all_eq, flag_none_eq}, 8'h02);
        cmd(3'd5, 8'hFF, 8'h7E); idle(1);
        chk("R7 with upper pins", {6'h0, flag_all_eq, flag_none_eq}, 8'h01);
        cmd(3'd2, 8'hFF, 8'h00); idle(2);
        // R8 mask covering only outputs
        cmd(3'd5, 8'h3C, 8'h00); idle(1);
        chk("R8 outputs only", {6'h0, flag_all_eq, flag_none_eq}, 8'h03);
        // R11 back to vector
        ctl(16'hFEFF); idle(1);
        chk("R11 released", {4'h0, pin_out[7:4]}, 8'h0C);
        idle(4);
        finish_run();
    end
endmodule